// File: doc/BRIEF.md
# Integer Min/Max Unit with Operand-Compare Flags

This block picks either the larger or the smaller of two 64-bit integer operands. The comparison can be signed (two's complement) or unsigned. An opcode chooses one of four operations: signed max, unsigned max, signed min and unsigned min. The result is registered and leaves the unit one cycle after the operation is accepted, together with an output valid strobe.

When record form is requested, the unit also writes a 4-bit condition field. This field records how the first operand compares with the second. It does not record the sign of the result. The upper three bits hold a one-hot less/greater/equal code, and the current summary-overflow bit is appended in bit 0. When record form is off, the condition write enable stays low.

Top module: `minmax_unit`

## Requirements
- R1: Max operations (op 2'b00 signed, 2'b01 unsigned) return operand A when A is strictly greater than B; otherwise they return operand B.
- R2: Min operations (op 2'b10 signed, 2'b11 unsigned) return operand A when A is strictly less than B; otherwise they return operand B.
- R3: Signed operations (op bit 0 = 0) compare in two's complement, so 0x8000_0000_0000_0000 is the most negative value. Unsigned operations (op bit 0 = 1) compare the operands as plain 64-bit magnitudes.
- R4: The condition field is {lt, gt, eq, so}, with so in bit 0. For A<B it is 4'b100s, for A>B it is 4'b010s, and for A==B it is 4'b001s. This operand-versus-operand code is the same for min and max.
- R5: The condition write enable is high only for an accepted operation with record form set. Without record form it stays low.
- R6: Result, condition field, condition write enable and output valid appear exactly one clock after input valid. Output valid is high for one cycle per accepted input.
- R7: Synchronous reset clears output valid and the condition write enable.
- R8: Exactly one of the three compare bits is set whenever the condition write enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation accepted this cycle |
| op | input | 2 | bit1: 0 max / 1 min; bit0: 0 signed / 1 unsigned |
| rec_en | input | 1 | Record form: write condition field |
| so_in | input | 1 | Current summary-overflow bit |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Selected operand |
| cond | output | 4 | {lt, gt, eq, so} |
| cond_we | output | 1 | Condition field write enable |

## Verification
The tests use operand pairs whose order differs between signed and unsigned comparison: a most-negative value against a positive one, and all-ones against zero. The same pair under both interpretations must give opposite selections and flags. Equal operands, including two most-negative values, show that ties return operand B and produce the equal code. Each pair is also run under min and max, with summary overflow both set and clear. This shows that the flags follow the operand order and not the result. Back-to-back and gapped valid patterns show that results line up with the cycle after input, and that record-form-off operations leave the write enable low.

// File: rtl/minmax_pkg.sv
package minmax_pkg;
   typedef enum logic [1:0] {
      OP_MAXS = 2'b00,
      OP_MAXU = 2'b01,
      OP_MINS = 2'b10,
      OP_MINU = 2'b11
   } mm_op_e;

   typedef struct packed {
      logic lt;
      logic gt;
      logic eq;
      logic so;
   } mm_cond_t;
endpackage

// File: rtl/minmax_cmp.sv
module minmax_cmp #(
   parameter int W = 64,
   parameter bit SPLIT_CMP = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         is_unsigned,
   output logic         lt,
   output logic         gt,
   output logic         eq
);
   localparam int HI = W - 1;

   initial begin
      if (W < 2) $error("minmax_cmp: W must be at least 2");
   end

   logic ult;
   logic sgn_diff;

   generate
      if (SPLIT_CMP) begin : g_split
         // magnitude compare once, sign bits fix up the signed case
         assign ult      = a < b;
         assign sgn_diff = a[HI] ^ b[HI];
         always_comb begin
            eq = (a == b);
            if (!is_unsigned && sgn_diff) lt = a[HI];
            else                          lt = ult;
            gt = !lt && !eq;
         end
      end else begin : g_direct
         assign ult      = a < b;
         assign sgn_diff = 1'b0;
         always_comb begin
            eq = (a == b);
            lt = is_unsigned ? ult : ($signed(a) < $signed(b));
            gt = is_unsigned ? (a > b) : ($signed(a) > $signed(b));
         end
      end
   endgenerate

   always_comb begin
      assert (!(lt && gt)) else $error("AST_CMP_EXCL");  // R8
   end
endmodule

// File: rtl/minmax_sel.sv
module minmax_sel #(
   parameter int W = 64
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         lt,
   input  logic         gt,
   input  logic         pick_min,
   output logic [W-1:0] y
);
   initial begin
      if (W < 1) $error("minmax_sel: bad width");
   end

   logic take_a;
   assign take_a = pick_min ? lt : gt;
   assign y      = take_a ? a : b;
endmodule

// File: rtl/minmax_unit.sv
module minmax_unit
   import minmax_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter bit SPLIT_CMP = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [1:0]        op,
   input  logic              rec_en,
   input  logic              so_in,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic [3:0]        cond,
   output logic              cond_we
);
   localparam int COND_W = $bits(mm_cond_t);

   initial begin
      if (DATA_W < 2) $error("minmax_unit: DATA_W too small");
      if (COND_W != 4) $error("minmax_unit: condition field must be 4 bits");
   end

   mm_op_e op_q;
   assign op_q = mm_op_e'(op);

   logic is_uns, pick_min;
   assign is_uns   = op_q[0];
   assign pick_min = op_q[1];

   logic c_lt, c_gt, c_eq;
   logic [DATA_W-1:0] sel;

   minmax_cmp #(.W(DATA_W), .SPLIT_CMP(SPLIT_CMP)) u_cmp (
      .a(opa), .b(opb), .is_unsigned(is_uns),
      .lt(c_lt), .gt(c_gt), .eq(c_eq)
   );

   minmax_sel #(.W(DATA_W)) u_sel (
      .a(opa), .b(opb), .lt(c_lt), .gt(c_gt),
      .pick_min(pick_min), .y(sel)
   );

   mm_cond_t cnext, creg;
   always_comb begin
      cnext.lt = c_lt;
      cnext.gt = c_gt;
      cnext.eq = c_eq;
      cnext.so = so_in;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         cond_we   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         cond_we   <= in_valid && rec_en;
      end
      if (in_valid) begin
         result <= sel;
         creg   <= cnext;
      end
   end

   assign cond = creg;

   AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!out_valid && !cond_we));  // R7
   AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);  // R6
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid);  // R6
   AST_WE_NEEDS_REC: assert property (@(posedge clk) disable iff (rst) (in_valid && !rec_en) |=> !cond_we);  // R5
   AST_WE_WITH_REC: assert property (@(posedge clk) disable iff (rst) (in_valid && rec_en) |=> cond_we);  // R5
   AST_CODE_ONEHOT: assert property (@(posedge clk) disable iff (rst) cond_we |-> $countones(cond[3:1]) == 1);  // R8
   AST_EQ_TIE_B: assert property (@(posedge clk) disable iff (rst) (out_valid && cond[1]) |-> result == $past(opb));  // R1
   AST_SO_CARRY: assert property (@(posedge clk) disable iff (rst) in_valid |=> cond[0] == $past(so_in));  // R4
endmodule

// File: tb/tb_minmax_unit.sv
module tb_minmax_unit;
   logic clk = 1'b0;
   logic rst;
   logic in_valid, rec_en, so_in;
   logic [1:0] op;
   logic [63:0] opa, opb;
   logic out_valid, cond_we;
   logic [63:0] result;
   logic [3:0] cond;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   minmax_unit dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .rec_en(rec_en),
      .so_in(so_in), .opa(opa), .opb(opb), .out_valid(out_valid),
      .result(result), .cond(cond), .cond_we(cond_we)
   );

   localparam logic [63:0] MNEG = 64'h8000_0000_0000_0000;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] ref_res(input logic [1:0] o, input logic [63:0] a, input logic [63:0] b);
      logic l, g;
      l = o[0] ? (a < b) : ($signed(a) < $signed(b));
      g = o[0] ? (a > b) : ($signed(a) > $signed(b));
      return o[1] ? (l ? a : b) : (g ? a : b);
   endfunction

   function automatic logic [3:0] ref_cond(input logic [1:0] o, input logic [63:0] a, input logic [63:0] b, input logic s);
      logic l, g;
      l = o[0] ? (a < b) : ($signed(a) < $signed(b));
      g = o[0] ? (a > b) : ($signed(a) > $signed(b));
      return {l, g, (a == b), s};
   endfunction

   // drive one op, check at next edge + half period
   task automatic run_op(input string req, input logic [1:0] o, input logic [63:0] a,
                         input logic [63:0] b, input logic r, input logic s);
      @(negedge clk);
      in_valid = 1'b1; op = o; opa = a; opb = b; rec_en = r; so_in = s;
      @(negedge clk);
      in_valid = 1'b0;
      chk({req, " valid"}, {63'd0, out_valid}, 64'd1);
      chk({req, " result"}, result, ref_res(o, a, b));
      chk({req, " we"}, {63'd0, cond_we}, {63'd0, r});
      if (r) chk({req, " cond"}, {60'd0, cond}, {60'd0, ref_cond(o, a, b, s)});
   endtask

   task automatic t_reset();
      rst = 1'b1; in_valid = 1'b1; rec_en = 1'b1; op = 2'b00; opa = 0; opb = 0; so_in = 0;
      repeat (3) @(negedge clk);
      chk("R7 valid", {63'd0, out_valid}, 64'd0);
      chk("R7 we", {63'd0, cond_we}, 64'd0);
      in_valid = 1'b0;
      rst = 1'b0;
      @(negedge clk);
      chk("R6 idle", {63'd0, out_valid}, 64'd0);
   endtask

   task automatic t_max();
      run_op("R1 maxs a>b", 2'b00, 64'd50, 64'd7, 1, 0);
      chk("R1 literal", result, 64'd50);
      run_op("R1 maxs b>a", 2'b00, 64'd7, 64'd50, 1, 0);
      chk("R4 literal 0x8", {60'd0, cond}, 64'h8);
      run_op("R1 maxs equal mneg", 2'b00, MNEG, MNEG, 1, 0);
      chk("R1 tie literal", result, MNEG);
      chk("R4 equal 0x2", {60'd0, cond}, 64'h2);
      run_op("R1 maxu", 2'b01, 64'd3, 64'd9, 1, 1);
   endtask

   task automatic t_sign();
      run_op("R3 maxs mneg vs 1", 2'b00, MNEG, 64'd1, 1, 0);
      chk("R3 signed pick", result, 64'd1);
      chk("R3 signed lt", {60'd0, cond}, 64'h8);
      run_op("R3 maxu mneg vs 1", 2'b01, MNEG, 64'd1, 1, 0);
      chk("R3 unsigned pick", result, MNEG);
      chk("R3 unsigned gt", {60'd0, cond}, 64'h4);
      run_op("R3 maxs ones vs 0", 2'b00, '1, 64'd0, 1, 1);
      chk("R3 ones signed", result, 64'd0);
      run_op("R3 minu ones vs 0", 2'b11, '1, 64'd0, 1, 1);
      chk("R3 ones unsigned", result, 64'd0);
   endtask

   task automatic t_min();
      run_op("R2 mins a<b", 2'b10, 64'd4, 64'd6, 1, 0);
      chk("R2 literal", result, 64'd4);
      chk("R4 min flag lt", {60'd0, cond}, 64'h8);
      run_op("R2 mins a>b", 2'b10, 64'd6, 64'd4, 1, 1);
      chk("R4 min flag gt so", {60'd0, cond}, 64'h5);
      run_op("R2 mins neg", 2'b10, MNEG, 64'd5, 1, 0);
      chk("R2 neg literal", result, MNEG);
      run_op("R2 minu equal", 2'b11, 64'd9, 64'd9, 1, 1);
      chk("R4 equal so", {60'd0, cond}, 64'h3);
   endtask

   task automatic t_norec();
      run_op("R5 no record", 2'b00, 64'd1, 64'd2, 0, 1);
      chk("R5 we low", {63'd0, cond_we}, 64'd0);
   endtask

   task automatic t_stream();
      @(negedge clk);
      in_valid = 1; op = 2'b00; opa = 64'd10; opb = 64'd20; rec_en = 1; so_in = 0;
      @(negedge clk);
      chk("R6 b2b first", result, 64'd20);
      op = 2'b10; opa = 64'd10; opb = 64'd20; rec_en = 0;
      @(negedge clk);
      in_valid = 0;
      chk("R6 b2b second", result, 64'd10);
      chk("R6 b2b valid", {63'd0, out_valid}, 64'd1);
      chk("R5 b2b we", {63'd0, cond_we}, 64'd0);
      @(negedge clk);
      chk("R6 gap", {63'd0, out_valid}, 64'd0);
      chk("R5 gap we", {63'd0, cond_we}, 64'd0);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog act=hang exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset();
      t_max();
      t_sign();
      t_min();
      t_norec();
      t_stream();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule